// File: doc/BRIEF.md
# Target Command/Address Handoff

This block sits between the bus-facing half of a target write path and the user logic that consumes each write. The bus side announces a new transaction with a one-cycle `start` pulse. With that pulse come the command code, the low and high address words, and two flags: one marks a burst and one marks a dual-address cycle. The block captures this descriptor and requests service from the application with an active-low request. It then hands over the command and address one word at a time, paced by the application's active-low address enable.

While the command/address phase is under way, the command sits on its own bus. The address words appear on the shared data-to-application bus, and the FIFO select is held high. The first address word carries the burst flag in bit 1 and the dual-address flag in bit 0. A dual-address cycle adds a second word that holds the high address. The final word is marked by an active-low last-cycle strobe.

When the application accepts the final word, the request is released and the select drops low. The data bus then carries the write-data FIFO output, until the data side reports the end of the transfer with `xfer_done`. After that the block returns to idle.

Top module: `ca_handoff`

## Requirements
- R1: After reset, `req_n`=1, `last_n`=1, `fifo_sel`=1, `cmd_o`=0 and `app_data`=0.
- R2: A `start` pulse while idle makes `req_n`=0 from the next cycle. At the same time `cmd_o` shows the captured command, `fifo_sel`=1, and `app_data` shows the first address word: the low address with bit 1 replaced by the burst flag and bit 0 replaced by the dual flag.
- R3: For a single-address transaction, `last_n`=0 accompanies the first word. One cycle after `aen_n`=0, `req_n`=1 and `fifo_sel`=0.
- R4: For a dual-address transaction, the first word has `last_n`=1. After it is accepted, `app_data` shows the high address with `last_n`=0 and `req_n` still 0. The request is released only after this second word is accepted.
- R5: While `req_n`=0 and `aen_n`=1, the presented word, `cmd_o`, `last_n` and `req_n` hold their values.
- R6: In the data phase, `fifo_sel`=0, `req_n`=1, `last_n`=1, and `app_data` follows `fifo_data` combinationally.
- R7: An `xfer_done` pulse in the data phase returns the block to idle on the next cycle, with `fifo_sel`=1, `app_data`=0 and `cmd_o`=0.
- R8: A `start` pulse while a transaction is active (request or data phase) is ignored: the command, the address words and the phase are unchanged.
- R9: `aen_n`=0 has no effect while `req_n`=1. An idle block stays idle, and a block in the data phase stays in the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | New-transaction pulse from the bus side |
| start_cmd | input | CMD_W | Command code of the new transaction |
| start_addr_lo | input | DW | Low address word |
| start_addr_hi | input | DW | High address word (used on dual-address cycles) |
| start_burst | input | 1 | Burst flag |
| start_dual | input | 1 | Dual-address flag |
| xfer_done | input | 1 | Data phase complete pulse from the data side |
| fifo_data | input | DW | Write-data FIFO output shown during the data phase |
| aen_n | input | 1 | Active-low address enable from the application |
| req_n | output | 1 | Active-low transaction request |
| cmd_o | output | CMD_W | Command bus |
| app_data | output | DW | Shared data-to-application bus |
| fifo_sel | output | 1 | 1 during idle and command/address phase, 0 in data phase |
| last_n | output | 1 | Active-low last command/address word strobe |

## Verification
The assertions take for granted that `start` and `xfer_done` are single-cycle pulses. They also assume that `xfer_done` arrives only after the select has dropped. The bench drives `xfer_done` only in the data phase, and the design ignores it in the other phases. The application enable, in contrast, is treated as free: it may be held low across phase boundaries or toggled at will. For that reason, the stimulus sweeps every command and flag combination, with and without stalls. It also keeps `aen_n` low into the data phase and while idle, and it fires stray `start` pulses in every busy phase.

// File: rtl/ca_pkg.sv
package ca_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // Build the first address word: flags overwrite the two low bits.
  function automatic logic [31:0] flag_word(input logic [31:0] addr,
                                            input logic burst,
                                            input logic dual);
    flag_word = {addr[31:2], burst, dual};
  endfunction

  // Number of command/address words a transaction carries.
  function automatic int unsigned word_total(input logic dual);
    word_total = dual ? 2 : 1;
  endfunction
endpackage

// File: rtl/ca_capture.sv
module ca_capture #(
  parameter int CMD_W = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMD_W-1:0] cmd_in,
  input  logic [DW-1:0]    lo_in,
  input  logic [DW-1:0]    hi_in,
  input  logic             burst_in,
  input  logic             dual_in,
  output logic [CMD_W-1:0] cmd_q,
  output logic [DW-1:0]    lo_q,
  output logic [DW-1:0]    hi_q,
  output logic             burst_q,
  output logic             dual_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      burst_q <= 1'b0;
      dual_q  <= 1'b0;
    end else if (load) begin
      cmd_q   <= cmd_in;
      lo_q    <= lo_in;
      hi_q    <= hi_in;
      burst_q <= burst_in;
      dual_q  <= dual_in;
    end
  end

  // R8: descriptor only changes on a load
  a_r8_hold_descriptor: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(cmd_q) && $stable(lo_q) && $stable(hi_q)
               && $stable(burst_q) && $stable(dual_q)));
endmodule

// File: rtl/ca_seq.sv
module ca_seq
  import ca_pkg::*;
#(
  parameter int MAX_WORDS = 2,
  localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             aen_n,
  input  logic             xfer_done,
  input  logic             dual_q,
  output phase_t           phase,
  output logic [IDX_W-1:0] idx,
  output logic             load,
  output logic             last_word,
  output logic             accept
);
  phase_t           phase_d;
  logic [IDX_W-1:0] idx_d;
  logic             finish_ca;

  assign load      = start && (phase == PH_IDLE);
  assign accept    = (phase == PH_ADDR) && !aen_n;
  assign last_word = (phase == PH_ADDR) &&
                     (int'(idx) == int'(word_total(dual_q)) - 1);
  assign finish_ca = accept && last_word;

  always_comb begin
    phase_d = phase;
    idx_d   = idx;
    unique case (phase)
      PH_IDLE: if (load) begin
        phase_d = PH_ADDR;
        idx_d   = '0;
      end
      PH_ADDR: if (finish_ca) begin
        phase_d = PH_DATA;
        idx_d   = '0;
      end else if (accept) begin
        idx_d = idx + 1'b1;
      end
      PH_DATA: if (xfer_done) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      phase <= phase_d;
      idx   <= idx_d;
    end
  end

  // R3: accepting the final word leaves the address phase
  a_r3_final_accept: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ca |=> (phase == PH_DATA));
  // R5: a stall keeps the current word
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR && aen_n) |=> (phase == PH_ADDR && $stable(idx)));
  // R9: enable outside the address phase changes nothing
  a_r9_data_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !xfer_done) |=> (phase == PH_DATA));
  // R8: start while busy does not restart
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR && start && !accept) |=> (phase == PH_ADDR && $stable(idx)));
endmodule

// File: rtl/ca_outmux.sv
module ca_outmux
  import ca_pkg::*;
#(
  parameter int CMD_W = 4,
  parameter int DW    = 32,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           phase,
  input  logic [IDX_W-1:0] idx,
  input  logic             last_word,
  input  logic [CMD_W-1:0] cmd_q,
  input  logic [DW-1:0]    lo_q,
  input  logic [DW-1:0]    hi_q,
  input  logic             burst_q,
  input  logic             dual_q,
  input  logic [DW-1:0]    fifo_data,
  output logic             req_n,
  output logic [CMD_W-1:0] cmd_o,
  output logic [DW-1:0]    app_data,
  output logic             fifo_sel,
  output logic             last_n
);
  logic [DW-1:0] first_word;

  generate
    if (DW == 32) begin : g_flag32
      assign first_word = flag_word(lo_q, burst_q, dual_q);
    end else begin : g_flagn
      assign first_word = {lo_q[DW-1:2], burst_q, dual_q};
    end
  endgenerate

  always_comb begin
    req_n    = 1'b1;
    cmd_o    = '0;
    app_data = '0;
    fifo_sel = 1'b1;
    last_n   = 1'b1;
    unique case (phase)
      PH_ADDR: begin
        req_n    = 1'b0;
        cmd_o    = cmd_q;
        app_data = (idx == '0) ? first_word : hi_q;
        last_n   = !last_word;
      end
      PH_DATA: begin
        fifo_sel = 1'b0;
        app_data = fifo_data;
      end
      default: ;
    endcase
  end

  // R6: data phase never shows a request or last strobe
  a_r6_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_sel |-> (req_n && last_n));
  // R3: last strobe only while requesting
  a_r3_last_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    !last_n |-> !req_n);
  // R7: idle bus is quiet
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_n && fifo_sel) |-> (app_data == '0 && cmd_o == '0));
endmodule

// File: rtl/ca_handoff.sv
module ca_handoff
  import ca_pkg::*;
#(
  parameter int CMD_W     = 4,
  parameter int DW        = 32,
  parameter int MAX_WORDS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CMD_W-1:0] start_cmd,
  input  logic [DW-1:0]    start_addr_lo,
  input  logic [DW-1:0]    start_addr_hi,
  input  logic             start_burst,
  input  logic             start_dual,
  input  logic             xfer_done,
  input  logic [DW-1:0]    fifo_data,
  input  logic             aen_n,
  output logic             req_n,
  output logic [CMD_W-1:0] cmd_o,
  output logic [DW-1:0]    app_data,
  output logic             fifo_sel,
  output logic             last_n
);
  localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  phase_t           phase;
  logic [IDX_W-1:0] idx;
  logic             load, last_word, accept;
  logic [CMD_W-1:0] cmd_q;
  logic [DW-1:0]    lo_q, hi_q;
  logic             burst_q, dual_q;

  ca_seq #(.MAX_WORDS(MAX_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .aen_n(aen_n),
    .xfer_done(xfer_done), .dual_q(dual_q), .phase(phase), .idx(idx),
    .load(load), .last_word(last_word), .accept(accept)
  );

  ca_capture #(.CMD_W(CMD_W), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(load), .cmd_in(start_cmd),
    .lo_in(start_addr_lo), .hi_in(start_addr_hi), .burst_in(start_burst),
    .dual_in(start_dual), .cmd_q(cmd_q), .lo_q(lo_q), .hi_q(hi_q),
    .burst_q(burst_q), .dual_q(dual_q)
  );

  ca_outmux #(.CMD_W(CMD_W), .DW(DW), .IDX_W(IDX_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .phase(phase), .idx(idx),
    .last_word(last_word), .cmd_q(cmd_q), .lo_q(lo_q), .hi_q(hi_q),
    .burst_q(burst_q), .dual_q(dual_q), .fifo_data(fifo_data),
    .req_n(req_n), .cmd_o(cmd_o), .app_data(app_data),
    .fifo_sel(fifo_sel), .last_n(last_n)
  );

  // R2: idle start raises the request next cycle
  a_r2_request: assert property (@(posedge clk) disable iff (!rst_n)
    (req_n && fifo_sel && start) |=> (!req_n && fifo_sel));
  // R4: a non-final accepted word keeps the request
  a_r4_keep_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && !aen_n && last_n) |=> (!req_n && !last_n));
  // R5: stalled request holds the visible word
  a_r5_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && aen_n) |=> ($stable(app_data) && $stable(cmd_o) && $stable(last_n) && !req_n));
endmodule

// File: tb/ca_handoff_tb.sv
module ca_handoff_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  start_cmd = '0;
  logic [31:0] start_addr_lo = '0, start_addr_hi = '0;
  logic        start_burst = 1'b0, start_dual = 1'b0;
  logic        xfer_done = 1'b0;
  logic [31:0] fifo_data = '0;
  logic        aen_n = 1'b1;
  logic        req_n, fifo_sel, last_n;
  logic [3:0]  cmd_o;
  logic [31:0] app_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ca_handoff u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cmd(start_cmd),
    .start_addr_lo(start_addr_lo), .start_addr_hi(start_addr_hi),
    .start_burst(start_burst), .start_dual(start_dual),
    .xfer_done(xfer_done), .fifo_data(fifo_data), .aen_n(aen_n),
    .req_n(req_n), .cmd_o(cmd_o), .app_data(app_data),
    .fifo_sel(fifo_sel), .last_n(last_n)
  );

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic run_txn(input logic [3:0] c, input logic b, input logic d,
                         input bit stall);
    logic [31:0] lo, hi, w0;
    lo = 32'h1000_0000 + {c, 8'h00, c, 12'h000} + {30'(c), 2'b11};
    hi = ~lo ^ {28'h0, c};
    w0 = {lo[31:2], b, d};
    start = 1'b1; start_cmd = c; start_addr_lo = lo; start_addr_hi = hi;
    start_burst = b; start_dual = d;
    step();
    start = 1'b0;
    chk("R2", "req_n", req_n, 0);
    chk("R2", "cmd_o", cmd_o, c);
    chk("R2", "word0", app_data, w0);
    chk("R2", "fifo_sel", fifo_sel, 1);
    chk(d ? "R4" : "R3", "last_n first", last_n, d);
    if (stall) begin
      // stray start during the address phase must be ignored
      start = 1'b1; start_cmd = ~c; start_addr_lo = ~lo; start_dual = ~d;
      step();
      start = 1'b0;
      chk("R8", "cmd kept", cmd_o, c);
      chk("R5", "word held", app_data, w0);
      chk("R5", "last held", last_n, d);
      step();
      chk("R5", "req held", req_n, 0);
      chk("R5", "word held2", app_data, w0);
    end
    aen_n = 1'b0;
    step();
    if (d) begin
      chk("R4", "req kept", req_n, 0);
      chk("R4", "high word", app_data, hi);
      chk("R4", "last_n second", last_n, 0);
      step();
    end
    // aen_n still low into the data phase
    chk(d ? "R4" : "R3", "req released", req_n, 1);
    chk("R3", "sel dropped", fifo_sel, 0);
    fifo_data = lo ^ 32'h5A5A_0000;
    #1;
    chk("R6", "data follows", app_data, lo ^ 32'h5A5A_0000);
    chk("R6", "last idle", last_n, 1);
    start = 1'b1; start_cmd = c + 4'd1;
    step();
    start = 1'b0; aen_n = 1'b1;
    chk("R9", "still data", fifo_sel, 0);
    chk("R8", "no restart", req_n, 1);
    fifo_data = hi;
    #1;
    chk("R6", "data follows2", app_data, hi);
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    chk("R7", "sel idle", fifo_sel, 1);
    chk("R7", "bus idle", app_data, 0);
    chk("R7", "cmd idle", cmd_o, 0);
    chk("R7", "req idle", req_n, 1);
  endtask

  initial begin
    #5;
    chk("R1", "req_n", req_n, 1);
    chk("R1", "last_n", last_n, 1);
    chk("R1", "fifo_sel", fifo_sel, 1);
    chk("R1", "cmd_o", cmd_o, 0);
    chk("R1", "app_data", app_data, 0);
    step();
    rst_n = 1'b1;
    step();
    aen_n = 1'b0;
    step();
    step();
    chk("R9", "idle ignores aen", req_n, 1);
    chk("R9", "idle sel", fifo_sel, 1);
    aen_n = 1'b1;
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 4; f++)
        run_txn(4'(c), f[1], f[0], (c % 2) == 1 || f == 3);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule